// File: doc/BRIEF.md
# Single-line bus bit-slot engine (1-Wire master)

This block is the bit-level master for a 1-Wire bus: one open-drain data line, a pull-up resistor and any number of slaves. On each command the engine runs one time slot on the line. The slot is a reset with presence detection, a write of a one, a write of a zero, or a read of one bit. The block never drives the line high. It asserts an output enable that pulls the line low, and it samples the returned level through a two-stage synchronizer.

Every interval is counted in ticks of an internal prescaler. The durations come from one of two built-in timing sets, a standard one and a fast one, chosen per command by a speed-select input. A host issues a command by pulsing `start` with a command code while `busy` is low. It then waits for the one-cycle `done` pulse and reads `readBit` or `presence`. Byte assembly, device search and anything above single slots belong to logic outside this block.

Top module: `onewire_slot_engine`

## Requirements
- R1: After reset, `lineOe`, `busy` and `done` are low, `presence` is 1 (no slave) and `readBit` is 0.
- R2: Command code 1 (write one) pulls the line low for LOW1 ticks, and `busy` stays high for SLOT + REC ticks in total.
- R3: Command code 2 (write zero) pulls the line low for LOW0 ticks, and `busy` stays high for SLOT + REC ticks.
- R4: Command code 3 (read) pulls the line low for LOWR ticks and then releases it. It samples the line RDV ticks after the slot began. `readBit` becomes 1 for a high line and 0 for a line a slave holds low. `busy` lasts SLOT + REC ticks.
- R5: Command code 0 (reset) pulls the line low for RSTL ticks, then releases it for RSTH ticks, then recovers for REC ticks. `busy` covers all three phases.
- R6: At the end of a reset, `presence` is 0 if the line was seen low after the RISE window during the released phase, and 1 if it stayed high. Value 3 never appears.
- R7: `presence` is 2 (bus fault) if the line is still low RISE ticks after release, or if it is low when the released phase ends.
- R8: `speedSel` is sampled only when a command is accepted: 0 selects the standard set and 1 selects the fast set. The whole command runs with the chosen set.
- R9: `start` is accepted only while `busy` is low. A start pulse during a command has no effect on the command's timing, its code or its result.
- R10: `done` is high for exactly one cycle, in the first cycle with `busy` low after a command. `readBit` and `presence` keep their values until a later command of the kind that updates them.
- R11: `lineOe` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request, taken when `busy` is low |
| cmd | input | 2 | Command code: 0 reset, 1 write one, 2 write zero, 3 read |
| speedSel | input | 1 | Timing set: 0 standard, 1 fast |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse at the end of a command |
| readBit | output | 1 | Last bit sampled by a read |
| presence | output | 2 | Last reset result: 0 slave found, 1 none, 2 fault |
| lineOe | output | 1 | Pull-down enable for the open-drain line |
| lineIn | input | 1 | Raw level of the data line |

## Verification
The assertions check the handshake rules on every cycle:
- `done` is a single cycle, arrives with `busy` low, and follows a busy cycle.
- An accepted start raises `busy`.
- The line is never pulled while idle.
- The results hold still between commands.
- `presence` never takes its unused code.

Slot durations, sample points and the three reset outcomes depend on how a slave answers on the line, so only the bench scenarios show them. In those scenarios a modelled slave answers, stays silent, sticks the line low or holds it low indefinitely, at both speeds.

// File: rtl/owse_pkg.sv
package owse_pkg;

  // Command codes seen on the cmd port
  localparam logic [1:0] OW_RESET  = 2'd0;
  localparam logic [1:0] OW_WRITE1 = 2'd1;
  localparam logic [1:0] OW_WRITE0 = 2'd2;
  localparam logic [1:0] OW_READ   = 2'd3;

  // Reset result codes
  localparam logic [1:0] PRES_FOUND = 2'd0;
  localparam logic [1:0] PRES_NONE  = 2'd1;
  localparam logic [1:0] PRES_FAULT = 2'd2;

  // Index of each interval inside a timing set
  localparam int LIM_RSTL  = 0;
  localparam int LIM_RSTH  = 1;
  localparam int LIM_RISE  = 2;
  localparam int LIM_LOW1  = 3;
  localparam int LIM_LOW0  = 4;
  localparam int LIM_LOWR  = 5;
  localparam int LIM_RDV   = 6;
  localparam int LIM_SLOT  = 7;
  localparam int LIM_REC   = 8;
  localparam int LIM_COUNT = 9;

  // Control to datapath
  typedef struct packed {
    logic loadCmd;     // latch command code and speed, clear reset flags
    logic clrCnt;      // restart prescaler and tick counter
    logic driveLow;    // pull the line low next cycle
    logic captureBit;  // read sample point
    logic watchLine;   // inside released phase of a reset
    logic riseCheck;   // end of rise window
    logic endCheck;    // end of released phase, commit presence
  } owStrobe_t;

  // Datapath to control: interval boundaries, each on a tick
  typedef struct packed {
    logic endRstLow;
    logic endRstHigh;
    logic atRise;
    logic endLow;
    logic atSample;
    logic endSlot;
    logic endRec;
  } owEvent_t;

endpackage

// File: rtl/owse_datapath.sv
module owse_datapath
  import owse_pkg::*;
#(
  parameter int TICK_DIV    = 250,
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter int STD_RSTL = 480, parameter int STD_RSTH = 480, parameter int STD_RISE = 15,
  parameter int STD_LOW1 = 6,   parameter int STD_LOW0 = 60,  parameter int STD_LOWR = 6,
  parameter int STD_RDV  = 15,  parameter int STD_SLOT = 65,  parameter int STD_REC  = 5,
  parameter int OD_RSTL  = 70,  parameter int OD_RSTH  = 48,  parameter int OD_RISE  = 2,
  parameter int OD_LOW1  = 1,   parameter int OD_LOW0  = 7,   parameter int OD_LOWR  = 1,
  parameter int OD_RDV   = 2,   parameter int OD_SLOT  = 8,   parameter int OD_REC   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  owStrobe_t  strobe,
  input  logic [1:0] cmdIn,
  input  logic       speedIn,
  input  logic       lineIn,
  output owEvent_t   ev,
  output logic       lineOe,
  output logic       readBit,
  output logic [1:0] presence
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  localparam logic [CNT_W-1:0] STD_TAB [LIM_COUNT] = '{
    CNT_W'(STD_RSTL), CNT_W'(STD_RSTH), CNT_W'(STD_RISE),
    CNT_W'(STD_LOW1), CNT_W'(STD_LOW0), CNT_W'(STD_LOWR),
    CNT_W'(STD_RDV),  CNT_W'(STD_SLOT), CNT_W'(STD_REC)};
  localparam logic [CNT_W-1:0] OD_TAB [LIM_COUNT] = '{
    CNT_W'(OD_RSTL), CNT_W'(OD_RSTH), CNT_W'(OD_RISE),
    CNT_W'(OD_LOW1), CNT_W'(OD_LOW0), CNT_W'(OD_LOWR),
    CNT_W'(OD_RDV),  CNT_W'(OD_SLOT), CNT_W'(OD_REC)};

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] tickCnt;
  logic             speedQ;
  logic [1:0]       cmdQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic             oeQ, bitQ, seenLow, faultQ;
  logic [1:0]       presQ;
  logic [CNT_W-1:0] activeLim [LIM_COUNT];
  logic [CNT_W-1:0] lowLim;
  logic             tickNow, lineLow;

  // Timing set chosen per command
  for (genvar i = 0; i < LIM_COUNT; i++) begin : g_lim
    assign activeLim[i] = speedQ ? OD_TAB[i] : STD_TAB[i];
  end

  always_comb begin
    unique case (cmdQ)
      OW_WRITE0: lowLim = activeLim[LIM_LOW0];
      OW_WRITE1: lowLim = activeLim[LIM_LOW1];
      default:   lowLim = activeLim[LIM_LOWR];
    endcase
  end

  assign tickNow = (preCnt == PRE_LAST);
  assign lineLow = ~syncQ[SYNC_STAGES-1];

  function automatic logic hitAt(input logic [CNT_W-1:0] lim,
                                 input logic [CNT_W-1:0] cnt,
                                 input logic tk);
    return tk && (cnt == lim - CNT_W'(1));
  endfunction

  always_comb begin
    ev.endRstLow  = hitAt(activeLim[LIM_RSTL], tickCnt, tickNow);
    ev.endRstHigh = hitAt(activeLim[LIM_RSTH], tickCnt, tickNow);
    ev.atRise     = hitAt(activeLim[LIM_RISE], tickCnt, tickNow);
    ev.endLow     = hitAt(lowLim,              tickCnt, tickNow);
    ev.atSample   = hitAt(activeLim[LIM_RDV],  tickCnt, tickNow);
    ev.endSlot    = hitAt(activeLim[LIM_SLOT], tickCnt, tickNow);
    ev.endRec     = hitAt(activeLim[LIM_REC],  tickCnt, tickNow);
  end

  // Prescaler and tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (strobe.clrCnt) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (tickNow) begin
      preCnt  <= '0;
      tickCnt <= tickCnt + CNT_W'(1);
    end else begin
      preCnt  <= preCnt + PRE_W'(1);
    end
  end

  // Input synchronizer, idles at the pulled-up level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
  end

  // Command context and line drive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      speedQ <= 1'b0;
      cmdQ   <= OW_RESET;
      oeQ    <= 1'b0;
    end else begin
      oeQ <= strobe.driveLow;
      if (strobe.loadCmd) begin
        speedQ <= speedIn;
        cmdQ   <= cmdIn;
      end
    end
  end

  // Read sample and reset classification
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitQ    <= 1'b0;
      seenLow <= 1'b0;
      faultQ  <= 1'b0;
      presQ   <= PRES_NONE;
    end else begin
      if (strobe.loadCmd) begin
        seenLow <= 1'b0;
        faultQ  <= 1'b0;
      end
      if (strobe.captureBit && cmdQ == OW_READ)
        bitQ <= ~lineLow;
      if (strobe.watchLine && lineLow && tickCnt >= activeLim[LIM_RISE])
        seenLow <= 1'b1;
      if (strobe.riseCheck && lineLow)
        faultQ <= 1'b1;
      if (strobe.endCheck) begin
        if (faultQ || lineLow) presQ <= PRES_FAULT;
        else if (seenLow)      presQ <= PRES_FOUND;
        else                   presQ <= PRES_NONE;
      end
    end
  end

  assign lineOe   = oeQ;
  assign readBit  = bitQ;
  assign presence = presQ;

endmodule

// File: rtl/owse_ctrl.sv
module owse_ctrl
  import owse_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] cmdIn,
  input  owEvent_t   ev,
  output owStrobe_t  strobe,
  output logic       busy,
  output logic       done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RST_LOW, ST_RST_HIGH, ST_SLOT_LOW, ST_SLOT_HIGH, ST_RECOVER
  } state_e;

  state_e state, stateNext;
  logic   doneSet, doneQ;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    doneSet   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.loadCmd = 1'b1;
          strobe.clrCnt  = 1'b1;
          stateNext = (cmdIn == OW_RESET) ? ST_RST_LOW : ST_SLOT_LOW;
        end
      end
      ST_RST_LOW: begin
        strobe.driveLow = 1'b1;
        if (ev.endRstLow) begin
          strobe.clrCnt = 1'b1;
          stateNext = ST_RST_HIGH;
        end
      end
      ST_RST_HIGH: begin
        strobe.watchLine = 1'b1;
        strobe.riseCheck = ev.atRise;
        if (ev.endRstHigh) begin
          strobe.endCheck = 1'b1;
          strobe.clrCnt   = 1'b1;
          stateNext = ST_RECOVER;
        end
      end
      ST_SLOT_LOW: begin
        strobe.driveLow = 1'b1;
        if (ev.endLow) stateNext = ST_SLOT_HIGH;
      end
      ST_SLOT_HIGH: begin
        strobe.captureBit = ev.atSample;
        if (ev.endSlot) begin
          strobe.clrCnt = 1'b1;
          stateNext = ST_RECOVER;
        end
      end
      ST_RECOVER: begin
        if (ev.endRec) begin
          doneSet   = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= doneSet;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;

endmodule

// File: rtl/onewire_slot_engine.sv
module onewire_slot_engine
  import owse_pkg::*;
#(
  parameter int TICK_DIV    = 250,
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter int STD_RSTL = 480, parameter int STD_RSTH = 480, parameter int STD_RISE = 15,
  parameter int STD_LOW1 = 6,   parameter int STD_LOW0 = 60,  parameter int STD_LOWR = 6,
  parameter int STD_RDV  = 15,  parameter int STD_SLOT = 65,  parameter int STD_REC  = 5,
  parameter int OD_RSTL  = 70,  parameter int OD_RSTH  = 48,  parameter int OD_RISE  = 2,
  parameter int OD_LOW1  = 1,   parameter int OD_LOW0  = 7,   parameter int OD_LOWR  = 1,
  parameter int OD_RDV   = 2,   parameter int OD_SLOT  = 8,   parameter int OD_REC   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] cmd,
  input  logic       speedSel,
  output logic       busy,
  output logic       done,
  output logic       readBit,
  output logic [1:0] presence,
  output logic       lineOe,
  input  logic       lineIn
);

  owStrobe_t strobe;
  owEvent_t  ev;

  owse_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .cmdIn  (cmd),
    .ev     (ev),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  owse_datapath #(
    .TICK_DIV(TICK_DIV), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES),
    .STD_RSTL(STD_RSTL), .STD_RSTH(STD_RSTH), .STD_RISE(STD_RISE),
    .STD_LOW1(STD_LOW1), .STD_LOW0(STD_LOW0), .STD_LOWR(STD_LOWR),
    .STD_RDV(STD_RDV),   .STD_SLOT(STD_SLOT), .STD_REC(STD_REC),
    .OD_RSTL(OD_RSTL),   .OD_RSTH(OD_RSTH),   .OD_RISE(OD_RISE),
    .OD_LOW1(OD_LOW1),   .OD_LOW0(OD_LOW0),   .OD_LOWR(OD_LOWR),
    .OD_RDV(OD_RDV),     .OD_SLOT(OD_SLOT),   .OD_REC(OD_REC)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdIn    (cmd),
    .speedIn  (speedSel),
    .lineIn   (lineIn),
    .ev       (ev),
    .lineOe   (lineOe),
    .readBit  (readBit),
    .presence (presence)
  );

endmodule

// File: rtl/owse_checker.sv
module owse_checker (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       readBit,
  input logic [1:0] presence,
  input logic       lineOe
);

  assert_idle_released_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !lineOe);

  assert_oe_rise_in_cmd_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineOe) |-> $past(busy));

  assert_start_taken_R9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  assert_results_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> ($stable(presence) && $stable(readBit)));

  assert_presence_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    presence != 2'b11);

endmodule

bind onewire_slot_engine owse_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .readBit  (readBit),
  .presence (presence),
  .lineOe   (lineOe)
);

// File: tb/onewire_slot_engine_tb_top.sv
module onewire_slot_engine_tb_top;

  localparam int DIV = 4;
  // Standard and fast sets in ticks (match the design defaults)
  localparam int S_RSTL = 480, S_RSTH = 480, S_LOW1 = 6, S_LOW0 = 60, S_LOWR = 6, S_SLOT = 65, S_REC = 5;
  localparam int F_RSTL = 70,  F_RSTH = 48,  F_LOW1 = 1, F_LOW0 = 7,  F_LOWR = 1, F_SLOT = 8,  F_REC = 2;

  localparam int M_NONE = 0, M_PRES = 1, M_STUCK = 2, M_LONG = 3, M_HOLD = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic       speedSel = 1'b0;
  logic       busy, done, readBit, lineOe, lineIn, slaveLow;
  logic [1:0] presence;

  always #2 clk = ~clk;   // 250 MHz

  onewire_slot_engine #(.TICK_DIV(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .speedSel(speedSel),
    .busy(busy), .done(done), .readBit(readBit), .presence(presence),
    .lineOe(lineOe), .lineIn(lineIn)
  );

  // Slave model on the wired line
  int slaveMode = M_NONE;
  int pStart = 120, pLen = 400, holdLen = 80;
  int relCnt = 100000;

  always @(posedge clk) relCnt <= lineOe ? 0 : relCnt + 1;

  assign slaveLow = (slaveMode == M_STUCK) ||
                    (slaveMode == M_PRES && relCnt >= pStart && relCnt < pStart + pLen) ||
                    (slaveMode == M_LONG && relCnt >= pStart) ||
                    (slaveMode == M_HOLD && relCnt < holdLen);
  assign lineIn = ~(lineOe | slaveLow);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct {
    string tag;
    int    oeLen;
    int    busyLen;
    int    bitv;
    int    pres;
  } exp_t;

  exp_t expQ[$];

  // Monitor: measures each command and compares with the scoreboard
  int oeCnt = 0, busyCnt = 0, oeIdle = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (lineOe) oeCnt++;
      if (busy) busyCnt++;
      if (lineOe && !busy) oeIdle++;
      if (done) begin
        if (expQ.size() == 0) begin
          check("R10 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check({e.tag, " low width"}, oeCnt, e.oeLen);
          check({e.tag, " busy length"}, busyCnt, e.busyLen);
          check({e.tag, " readBit"}, int'(readBit), e.bitv);
          check({e.tag, " presence"}, int'(presence), e.pres);
        end
        oeCnt = 0;
        busyCnt = 0;
      end
    end
  end

  // Driver
  task automatic runCmd(input logic [1:0] c, input logic spd, input int mode,
                        input string tag, input int oeT, input int busyT,
                        input int expBit, input int expPres, input bit noise);
    exp_t e;
    slaveMode = mode;
    e.tag = tag; e.oeLen = oeT * DIV; e.busyLen = busyT * DIV;
    e.bitv = expBit; e.pres = expPres;
    expQ.push_back(e);
    @(negedge clk);
    cmd = c; speedSel = spd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (noise) begin
      // R9: a second request mid-command must be ignored
      repeat (6) @(negedge clk);
      cmd = (c == 2'd0) ? 2'd3 : 2'd0;
      speedSel = ~spd;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check({tag, " R10 done width"}, int'(done), 0);
    slaveMode = M_NONE;
    repeat (3) @(negedge clk);
    check({tag, " R9 stays idle"}, int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 lineOe", int'(lineOe), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 presence", int'(presence), 1);
    check("R1 readBit", int'(readBit), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 done", int'(done), 0);
    check("R1 busy after release", int'(busy), 0);

    // Standard speed, reset outcomes (R5, R6, R7)
    pStart = 120; pLen = 400;
    runCmd(2'd0, 1'b0, M_PRES,  "R5 R6 std found", S_RSTL, S_RSTL+S_RSTH+S_REC, 0, 0, 0);
    runCmd(2'd0, 1'b0, M_NONE,  "R6 std none",     S_RSTL, S_RSTL+S_RSTH+S_REC, 0, 1, 0);
    runCmd(2'd0, 1'b0, M_STUCK, "R7 std stuck",    S_RSTL, S_RSTL+S_RSTH+S_REC, 0, 2, 0);
    runCmd(2'd0, 1'b0, M_LONG,  "R7 std long low", S_RSTL, S_RSTL+S_RSTH+S_REC, 0, 2, 0);

    // Standard slots (R2, R3, R4, R9, R10)
    holdLen = 80;
    runCmd(2'd1, 1'b0, M_NONE, "R2 R9 std write one", S_LOW1, S_SLOT+S_REC, 0, 2, 1);
    runCmd(2'd2, 1'b0, M_NONE, "R3 std write zero",   S_LOW0, S_SLOT+S_REC, 0, 2, 0);
    runCmd(2'd3, 1'b0, M_NONE, "R4 std read high",    S_LOWR, S_SLOT+S_REC, 1, 2, 0);
    runCmd(2'd3, 1'b0, M_HOLD, "R4 std read low",     S_LOWR, S_SLOT+S_REC, 0, 2, 0);
    runCmd(2'd1, 1'b0, M_NONE, "R10 bit held",        S_LOW1, S_SLOT+S_REC, 0, 2, 0);

    // Fast set (R8)
    pStart = 20; pLen = 80; holdLen = 16;
    runCmd(2'd0, 1'b1, M_PRES, "R8 fast reset found", F_RSTL, F_RSTL+F_RSTH+F_REC, 0, 0, 0);
    runCmd(2'd0, 1'b1, M_STUCK,"R8 R7 fast stuck",    F_RSTL, F_RSTL+F_RSTH+F_REC, 0, 2, 0);
    runCmd(2'd1, 1'b1, M_NONE, "R8 fast write one",   F_LOW1, F_SLOT+F_REC, 0, 2, 1);
    runCmd(2'd2, 1'b1, M_NONE, "R8 fast write zero",  F_LOW0, F_SLOT+F_REC, 0, 2, 0);
    runCmd(2'd3, 1'b1, M_NONE, "R8 fast read high",   F_LOWR, F_SLOT+F_REC, 1, 2, 0);
    runCmd(2'd3, 1'b1, M_HOLD, "R8 fast read low",    F_LOWR, F_SLOT+F_REC, 0, 2, 0);
    runCmd(2'd0, 1'b0, M_NONE, "R6 R8 back to std",   S_RSTL, S_RSTL+S_RSTH+S_REC, 0, 1, 0);

    check("R11 line pulled while idle", oeIdle, 0);
    check("R10 scoreboard drained", expQ.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R10 watchdog: actual no completion expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule